// File: doc/BRIEF.md
# Periodic Countdown Timer Channel

A single timer channel that counts ticks down from a programmed preset. The tick comes from one of several tick inputs, chosen by a source-select register. Source 0 is the microsecond tick. When a tick arrives while the count is already zero, the channel expires. On expiry it emits a one-cycle expiration pulse and sets a sticky interrupt flag. In periodic mode it then reloads the preset and keeps counting. In one-shot mode it halts. A watchdog stage downstream can consume the expiration pulse directly.

Software reaches the channel through a plain 32-bit register port. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address.

The sequencer has two states, `ST_IDLE` and `ST_RUN`, with these transitions:

- `ARM`: from `ST_IDLE` to `ST_RUN`, on a control write with the enable bit set.
- `REARM`: from `ST_RUN` back to `ST_RUN`, on a control write with the enable bit set. It reloads the preset.
- `RELOAD`: from `ST_RUN` back to `ST_RUN`, on expiry in periodic mode.
- `HALT`: from `ST_RUN` to `ST_IDLE`, on a control write with the enable bit clear, or on expiry in one-shot mode.

Top module: `cdt_channel`

## Requirements
- R1: After reset, the control register, the status register, the source register, `expire_o` and `irq_o` are all zero.
- R2: The control register is at address 0. Bit 31 is enable, bit 30 is periodic, and bits 27:0 are the preset. Bits 29:28 are dropped on write and read back as 0. Bit 31 reads back 1 exactly while the channel is in `ST_RUN`.
- R3: A control write with bit 31 set loads the preset into the count. Each selected tick in `ST_RUN` with a nonzero count lowers the count by one. Cycles without a tick leave the count unchanged.
- R4: A selected tick in `ST_RUN` while the count is 0 is an expiry. `expire_o` is high for exactly the one cycle after that tick's edge, and `irq_o` becomes 1. With preset P, expiry happens on the (P+1)th tick after loading.
- R5: In periodic mode, an expiry reloads the count with the preset and the channel stays in `ST_RUN`.
- R6: In one-shot mode, an expiry moves the channel to `ST_IDLE`. The enable bit reads back 0, the count stays 0, and further ticks cause no expiry.
- R7: The status register is at address 1. Bit 30 is the interrupt flag and bits 27:0 are the current count. Writing 1 to bit 30 clears the flag. Writing 0 to bit 30 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R8: The source register is at address 2. Value s selects `tick_src[s]`, so 0 selects the microsecond tick. Ticks on the other inputs are ignored, and a value of s >= NSRC selects no tick at all.
- R9: A control write of zero stops the channel. The count holds its value and no expiry follows, whatever ticks arrive.
- R10: A control write with bit 31 set while in `ST_RUN` restarts the count from the new preset. A control write has priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 source |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tick_src | input | NSRC | Single-cycle tick pulses, one per source |
| expire_o | output | 1 | One-cycle expiration pulse |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
Presets 0 through 5 are each run in both periodic and one-shot mode, one tick at a time. The count, the expiration pulse and the flag are predicted arithmetically after every tick. This separates an off-by-one expiry point, a missing reload and a one-shot that keeps firing. Further directed patterns cover the following:

- Ticks on unselected and out-of-range sources, which show whether the source mux is honoured.
- A stop write followed by ticks.
- A re-arm in mid-count.
- A clear written in the same cycle as an expiry, which shows the set-over-clear priority.
- An all-ones control write, which exposes the field masking.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_STAT = 2'd1;
    localparam logic [REG_AW-1:0] A_SRC  = 2'd2;

    localparam int B_EN  = 31;
    localparam int B_PER = 30;
    localparam int B_IRQ = 30;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cdt_state_e;
endpackage

// File: rtl/cdt_tick_mux.sv
module cdt_tick_mux #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 4
) (
    input  logic [NSRC-1:0]  tick_src,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [NSRC-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            assign hit[g] = tick_src[g] && (sel == SEL_W'(g));
        end
    endgenerate

    assign tick = |hit;
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ctl_wr,
    output logic              clr_wr,
    output logic [SEL_W-1:0]  sel_q,
    input  logic              running,
    input  logic              per_q,
    input  logic [CNT_W-1:0]  preset_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              irq_q
);
    assign ctl_wr = bus_we && (bus_addr == A_CTRL);
    assign clr_wr = bus_we && (bus_addr == A_STAT) && bus_wdata[B_IRQ];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (bus_we && (bus_addr == A_SRC)) begin
            sel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]        = running;
                bus_rdata[B_PER]       = per_q;
                bus_rdata[CNT_W-1:0]   = preset_q;
            end
            A_STAT: begin
                bus_rdata[B_IRQ]       = irq_q;
                bus_rdata[CNT_W-1:0]   = cnt_q;
            end
            A_SRC:   bus_rdata[SEL_W-1:0] = sel_q;
            default: bus_rdata = '0;
        endcase
    end

    AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_SRC) |=> $stable(sel_q)); // R8
endmodule

// File: rtl/cdt_core.sv
module cdt_core
    import cdt_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [31:0]      wdata,
    input  logic             clr_wr,
    input  logic             tick,
    output logic             running,
    output logic             per_q,
    output logic [CNT_W-1:0] preset_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_q,
    output logic             exp_q
);
    cdt_state_e state_q, state_d;
    logic       fire;

    assign fire = (state_q == ST_RUN) && tick && !ctl_wr && (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctl_wr && wdata[B_EN]) state_d = ST_RUN;
            ST_RUN: begin
                if (ctl_wr)             state_d = wdata[B_EN] ? ST_RUN : ST_IDLE;
                else if (fire && !per_q) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q    <= 1'b0;
            preset_q <= '0;
            cnt_q    <= '0;
            irq_q    <= 1'b0;
            exp_q    <= 1'b0;
        end else begin
            exp_q <= fire;
            if (ctl_wr) begin
                per_q    <= wdata[B_PER];
                preset_q <= wdata[CNT_W-1:0];
                if (wdata[B_EN]) cnt_q <= wdata[CNT_W-1:0];
            end else if (state_q == ST_RUN && tick) begin
                if (cnt_q == '0) begin
                    if (per_q) cnt_q <= preset_q;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (fire)        irq_q <= 1'b1;
            else if (clr_wr) irq_q <= 1'b0;
        end
    end

    assign running = (state_q == ST_RUN);

    AST_IRQ_WITH_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q |-> irq_q); // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt_q <= preset_q); // R3
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q && per_q |-> running && cnt_q == preset_q); // R5
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q && !per_q |-> !running && cnt_q == '0); // R6
    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !fire |=> !irq_q); // R7
    AST_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !wdata[B_EN] |=> !running && !exp_q); // R9
    AST_REARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && wdata[B_EN] |=> running && cnt_q == preset_q && !exp_q); // R10
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int NSRC  = 4,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   tick_src,
    output logic              expire_o,
    output logic              irq_o
);
    logic             ctl_wr, clr_wr, tick, running, per_q, irq_q, exp_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] preset_q, cnt_q;

    cdt_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_wr(ctl_wr),
        .clr_wr(clr_wr), .sel_q(sel_q), .running(running), .per_q(per_q),
        .preset_q(preset_q), .cnt_q(cnt_q), .irq_q(irq_q)
    );

    cdt_tick_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
        .tick_src(tick_src), .sel(sel_q), .tick(tick)
    );

    cdt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(bus_wdata),
        .clr_wr(clr_wr), .tick(tick), .running(running), .per_q(per_q),
        .preset_q(preset_q), .cnt_q(cnt_q), .irq_q(irq_q), .exp_q(exp_q)
    );

    assign expire_o = exp_q;
    assign irq_o    = irq_q;
endmodule

// File: tb/tb_cdt_channel.sv
module tb_cdt_channel;
    localparam int NSRC = 4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0] tick_src = '0;
    logic        expire_o, irq_o;
    int checks = 0;
    int fails = 0;

    cdt_channel dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src),
        .expire_o(expire_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tk(input int idx);
        @(negedge clk);
        tick_src[idx] = 1'b1;
        @(negedge clk);
        tick_src = '0;
    endtask

    function automatic logic [31:0] ctl(input bit en, input bit per, input int p);
        return {en, per, 2'b00, 28'(p)};
    endfunction

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, d); chk("R1 ctrl", d, 0);
        rd(1, d); chk("R1 stat", d, 0);
        rd(2, d); chk("R1 src", d, 0);
        chk("R1 expire", {31'b0, expire_o}, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);

        for (int per = 0; per < 2; per++) begin
            for (int p = 0; p < 6; p++) begin
                int nt;
                wr(1, 32'h4000_0000);
                wr(0, ctl(1, per[0], p));
                rd(1, d); chk("R3 load", d, p);
                nt = per ? 2 * (p + 1) : p + 1;
                for (int k = 1; k <= nt; k++) begin
                    int ph;
                    int ecnt;
                    ph = k % (p + 1);
                    tk(0);
                    chk(per ? "R5 pulse" : "R4 pulse", {31'b0, expire_o}, (ph == 0) ? 1 : 0);
                    if (ph == 0) ecnt = per ? p : 0;
                    else         ecnt = p - ph;
                    rd(1, d);
                    chk(per ? "R5 count" : "R3 count", d,
                        {1'b0, (k >= p + 1), 2'b00, 28'(ecnt)});
                end
                @(negedge clk);
                chk("R4 one-cycle", {31'b0, expire_o}, 0);
                rd(0, d);
                chk(per ? "R5 still running" : "R6 enable clear", d, ctl(per[0], per[0], p));
                if (per == 0) begin
                    tk(0);
                    chk("R6 no refire", {31'b0, expire_o}, 0);
                    rd(1, d); chk("R6 count zero", d, 32'h4000_0000);
                end
            end
        end

        wr(1, 32'h0000_0000);
        chk("R7 zero write ignored", {31'b0, irq_o}, 1);
        wr(1, 32'h4000_0000);
        chk("R7 clear", {31'b0, irq_o}, 0);

        wr(0, ctl(1, 1, 0));
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 32'h4000_0000; bus_we = 1'b1; tick_src[0] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_src = '0;
        chk("R7 set wins pulse", {31'b0, expire_o}, 1);
        chk("R7 set wins flag", {31'b0, irq_o}, 1);
        wr(1, 32'h4000_0000);

        wr(0, ctl(1, 1, 5));
        wr(2, 2);
        rd(2, d); chk("R8 src readback", d, 2);
        tk(0); tk(1); tk(3);
        rd(1, d); chk("R8 unselected ignored", d, 5);
        tk(2);
        rd(1, d); chk("R8 selected counts", d, 4);
        wr(2, 9);
        for (int i = 0; i < NSRC; i++) tk(i);
        rd(1, d); chk("R8 out of range", d, 4);
        wr(2, 0);

        wr(0, ctl(1, 0, 3));
        tk(0);
        wr(0, 0);
        for (int i = 0; i < 6; i++) begin
            tk(0);
            chk("R9 no expire", {31'b0, expire_o}, 0);
        end
        rd(1, d); chk("R9 count held", d, 2);
        rd(0, d); chk("R9 stopped", d, 0);

        wr(0, ctl(1, 1, 4));
        tk(0); tk(0);
        rd(1, d); chk("R10 mid", d, 2);
        wr(0, ctl(1, 1, 7));
        rd(1, d); chk("R10 reload", d, 7);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = ctl(1, 1, 3); bus_we = 1'b1; tick_src[0] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_src = '0;
        rd(1, d); chk("R10 write beats tick", d, 3);

        wr(0, 32'hFFFF_FFFF);
        rd(0, d); chk("R2 mask", d, 32'hCFFF_FFFF);
        rd(1, d); chk("R2 preset", d, 32'h0FFF_FFFF);
        wr(0, 0);
        rd(0, d); chk("R2 disable readback", d, 32'h4000_0000 ^ 32'h4000_0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule